// File: doc/BRIEF.md
# Randomly Polarised Triangular Carrier

The block produces a digital triangle for a PWM comparator. At the start of every carrier period it decides whether the triangle is used as is or turned upside down. The upside-down copy has the same frequency, the same peak and the same valley. A bit from an 8-bit pseudo-random shift register makes the choice. Because the choice keeps changing, the output spectrum no longer clusters at multiples of the carrier frequency. The polarity is fixed for the whole of each period, so the comparator never sees a jump in the middle of a period.

The period is given in clock ticks on `period_i`. At a 50 MHz clock, a 1.5 kHz carrier needs a value of about 33333. Period length and seed are captured only at a period boundary. A single-cycle strobe marks the first cycle of every period, and the random bit in use is brought out beside the carrier sample.

Top module: `rnd_tri_carrier`

## Requirements
- R1: While reset is asserted, `carrier_o`, `rand_bit_o` and `strobe_o` are all 0.
- R2: The first clock edge after reset starts a period. It loads the shift register from `seed_i`, or from 0xB5 when `seed_i` is zero, and sets `rand_bit_o` to bit 0 of the loaded value.
- R3: At every later period start the 8-bit register steps once with feedback s[7]^s[5]^s[4]^s[3], shifted into bit 0 as {s[6:0],fb}. `rand_bit_o` takes the new bit 0, and the register never holds zero.
- R4: `strobe_o` is high for exactly the first cycle of each period, and periods last P cycles. P is `period_i` captured at the period start, with values below 2 treated as 2.
- R5: With phase t counting 0..P-1 from the strobe cycle and H = floor(P/2), the base triangle is t for t <= H and P-t otherwise. Between consecutive cycles of the same period it moves by at most 1.
- R6: When `rand_bit_o` is 1, `carrier_o` equals the base triangle. When it is 0, `carrier_o` equals H minus the base triangle, so it never exceeds H.
- R7: `rand_bit_o` changes only in a cycle where `strobe_o` is high.
- R8: A change of `period_i` during a period does not affect the current period. It takes effect from the next period start.
- R9: `seed_i` is ignored after the first period start following reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seed_i | input | 8 | Shift register seed, sampled at the first period start |
| period_i | input | CNT_W | Carrier period in clock ticks |
| carrier_o | output | CNT_W | Selected triangle sample |
| rand_bit_o | output | 1 | Polarity bit in use (1 = normal, 0 = inverted) |
| strobe_o | output | 1 | High in the first cycle of each period |

## Verification
On every cycle the assertions check these properties:
- the strobe is a single pulse that coincides with phase zero;
- the polarity bit holds between strobes;
- the carrier stays within the peak and moves by at most one step inside a period;
- the shift register never reaches zero;
- the random bit in use matches the register at every strobe.

Some behaviour can be shown only by the bench scenarios. These cover the exact feedback sequence, the zero-seed substitution, the period clamp, the exact triangle values for both polarities at odd and even periods, and the refusal to take a new period or seed in the middle of a run. For these the bench compares every output on every cycle against its own arithmetic model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned LFSR_W = 8;
  typedef logic [LFSR_W-1:0] lfsr_t;

  // x^8+x^6+x^5+x^4+1, Fibonacci form, new bit enters at bit 0
  function automatic lfsr_t lfsr_step(lfsr_t s);
    return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/rtc_lfsr.sv
module rtc_lfsr
  import rtc_pkg::*;
#(
  parameter lfsr_t DEF_SEED = 8'hB5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  adv_i,
  input  lfsr_t seed_i,
  output lfsr_t state_o,
  output logic  nxt_bit_o
);
  lfsr_t state_q, seed_eff, stepped;

  assign seed_eff = (seed_i == '0) ? DEF_SEED : seed_i;
  assign stepped  = lfsr_step(state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= DEF_SEED;
    else if (load_i) state_q <= seed_eff;
    else if (adv_i)  state_q <= stepped;
  end

  // bit that bit 0 will hold after this edge
  assign nxt_bit_o = load_i ? seed_eff[0] : stepped[0];
  assign state_o   = state_q;

  p_lfsr_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  p_lfsr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> state_q == {$past(state_q[6:0]),
      $past(state_q[7] ^ state_q[5] ^ state_q[4] ^ state_q[3])});
endmodule

// File: rtl/rtc_tri_gen.sv
module rtc_tri_gen #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic             bnd_o,
  output logic             first_o,
  output logic             strobe_o,
  output logic [CNT_W-1:0] tri_o,
  output logic [CNT_W-1:0] half_o
);
  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

  logic             started_q, strobe_q;
  logic [CNT_W-1:0] ph_q, per_q, per_eff;

  assign per_eff = (period_i < MIN_PER) ? MIN_PER : period_i;
  assign first_o = !started_q;
  assign bnd_o   = !started_q || (ph_q == per_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      strobe_q  <= 1'b0;
      ph_q      <= '0;
      per_q     <= '0;
    end else if (bnd_o) begin
      started_q <= 1'b1;
      strobe_q  <= 1'b1;
      ph_q      <= '0;
      per_q     <= per_eff;
    end else begin
      strobe_q  <= 1'b0;
      ph_q      <= ph_q + CNT_W'(1);
    end
  end

  assign half_o   = per_q >> 1;
  assign tri_o    = (ph_q <= half_o) ? ph_q : (per_q - ph_q);
  assign strobe_o = strobe_q;

  p_strobe_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);
  p_strobe_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> ph_q == '0 && per_q >= MIN_PER);
  p_period_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && !bnd_o |=> $stable(per_q));
  p_tri_peak_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_o <= half_o);
endmodule

// File: rtl/rtc_sel.sv
module rtc_sel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bnd_i,
  input  logic             bit_i,
  input  logic [CNT_W-1:0] tri_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             sel_o,
  output logic [CNT_W-1:0] carrier_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= 1'b0;
    else if (bnd_i) sel_q <= bit_i;
  end

  // 1 -> normal, 0 -> inverted about the same peak
  assign carrier_o = sel_q ? tri_i : (half_i - tri_i);
  assign sel_o     = sel_q;

  p_sel_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> $stable(sel_q));
  p_carrier_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_o <= half_i);
endmodule

// File: rtl/rnd_tri_carrier.sv
module rnd_tri_carrier
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter lfsr_t       DEF_SEED = 8'hB5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       seed_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] carrier_o,
  output logic             rand_bit_o,
  output logic             strobe_o
);
  logic             bnd, first, nxt_bit;
  logic [CNT_W-1:0] tri_v, half_v;
  lfsr_t            lfsr_state;

  rtc_tri_gen #(.CNT_W(CNT_W)) u_tri (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .bnd_o    (bnd),
    .first_o  (first),
    .strobe_o (strobe_o),
    .tri_o    (tri_v),
    .half_o   (half_v)
  );

  rtc_lfsr #(.DEF_SEED(DEF_SEED)) u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (bnd && first),
    .adv_i     (bnd && !first),
    .seed_i    (seed_i),
    .state_o   (lfsr_state),
    .nxt_bit_o (nxt_bit)
  );

  rtc_sel #(.CNT_W(CNT_W)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bnd_i     (bnd),
    .bit_i     (nxt_bit),
    .tri_i     (tri_v),
    .half_i    (half_v),
    .sel_o     (rand_bit_o),
    .carrier_o (carrier_o)
  );

  p_strobe_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> rand_bit_o == lfsr_state[0]);
  p_bit_only_at_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(rand_bit_o));
  p_slope_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> ((carrier_o >= $past(carrier_o)) ? (carrier_o - $past(carrier_o))
                   : ($past(carrier_o) - carrier_o)) <= CNT_W'(1));
endmodule

// File: tb/rnd_tri_carrier_test.sv
module rnd_tri_carrier_test;
  localparam int CLK_PERIOD = 20;
  localparam int CNT_W      = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       seed = 8'h00;
  logic [CNT_W-1:0] period = '0;
  logic [CNT_W-1:0] carrier;
  logic             rand_bit, strobe;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // bench model
  bit       m_started;
  bit [7:0] m_lfsr;
  bit       m_sel, m_strobe;
  int       m_per, m_ph;
  string    tag_c = "R5 R6", tag_b = "R3 R7", tag_s = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  rnd_tri_carrier #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .seed_i(seed), .period_i(period),
    .carrier_o(carrier), .rand_bit_o(rand_bit), .strobe_o(strobe)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int p = (int'(period) < 2) ? 2 : int'(period);
    if (!m_started) begin
      m_started = 1; m_lfsr = (seed == 0) ? 8'hB5 : seed;
      m_sel = m_lfsr[0]; m_per = p; m_ph = 0; m_strobe = 1;
    end else if (m_ph == m_per - 1) begin
      m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
      m_sel = m_lfsr[0]; m_per = p; m_ph = 0; m_strobe = 1;
    end else begin
      m_ph++; m_strobe = 0;
    end
  endtask

  function automatic int exp_carrier();
    int h, t;
    if (!m_started) return 0;
    h = m_per / 2;
    t = (m_ph <= h) ? m_ph : m_per - m_ph;
    return m_sel ? t : h - t;
  endfunction

  task automatic compare_all();
    chk(tag_c, "carrier", int'(carrier), exp_carrier());
    chk(tag_b, "rand_bit", int'(rand_bit), int'(m_sel));
    chk(tag_s, "strobe", int'(strobe), int'(m_strobe));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(logic [7:0] s, int p);
    @(negedge clk);
    rst_n = 1'b0; seed = s; period = CNT_W'(p);
    m_started = 0; m_sel = 0; m_strobe = 0; m_ph = 0; m_per = 0;
    @(negedge clk);
    chk("R1", "reset carrier", int'(carrier), 0);
    chk("R1", "reset rand_bit", int'(rand_bit), 0);
    chk("R1", "reset strobe", int'(strobe), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    // R2: zero seed replaced by default
    do_reset(8'h00, 4);
    tag_b = "R2"; tag_s = "R2";
    cycle();
    tag_b = "R3 R7"; tag_s = "R4";
    for (int i = 0; i < 20; i++) cycle();

    // R5 R6: sweep of periods, both parities, several periods each
    for (int p = 2; p <= 13; p++) begin
      do_reset(8'(8'h11 * p + 3), p);
      for (int i = 0; i < 4 * p + 1; i++) cycle();
    end

    // R4: clamp of period 0 and 1
    tag_s = "R4"; tag_c = "R4 R5";
    do_reset(8'h3C, 0);
    for (int i = 0; i < 12; i++) cycle();
    period = 1;
    for (int i = 0; i < 12; i++) cycle();

    // R8: period changes mid-period
    tag_c = "R8"; tag_s = "R8";
    do_reset(8'h5A, 10);
    for (int i = 0; i < 80; i++) begin
      if (i % 3 == 1) period = CNT_W'(3 + (i % 7));
      cycle();
    end

    // R9: seed changes after start are ignored
    tag_c = "R5 R6"; tag_s = "R4"; tag_b = "R9";
    do_reset(8'h01, 3);
    for (int i = 0; i < 60; i++) begin
      seed = 8'(i * 37 + 1);
      cycle();
    end

    // R3: full sequence length at minimum period
    tag_b = "R3";
    seed = 8'hE7; do_reset(8'hE7, 2);
    for (int i = 0; i < 2 * 260; i++) cycle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule